// File: doc/BRIEF.md
# Stack Frame Prepare Sequencer

This block carries out the entry step of a called function. A twelve-bit mask names which callee-saved registers must be kept. The block pushes each of those registers onto the stack as one word. Each push first lowers the stack pointer by four and then writes the register to the new address. When every selected register has been written, the block lowers the stack pointer again by a small unsigned frame size to make room for locals. As an option, it then hands back one extra value for a load: the resulting stack pointer, or an immediate that trails the instruction.

The controlling pipeline pulses `start` with the mask, the frame size, the option field, the current stack pointer and the trailing immediate (already fetched). The block reads register values through a combinational read port. It issues word stores on a write port that has a ready handshake, and it keeps `busy` high while it works. When it finishes, it pulses `done`, and the final stack pointer is valid on `sp_out` from that cycle on.

Top module: `frame_push_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_wvalid` and `ext_we` are all low, and no store is offered while `busy` is low.
- R2: Mask bit i selects register number 20+i. Selected registers are stored from the highest bit to the lowest. The k-th store (k = 1, 2, ...) goes to address `sp_in - 4k` and carries the word read at `rf_raddr` = 20+i.
- R3: A store that is not accepted (`mem_wready` low) keeps `mem_wvalid`, `mem_waddr` and `mem_wdata` unchanged into the next cycle. The stack pointer does not move until the store is accepted.
- R4: The final stack pointer is `sp_in - 4n - zero_extend(frame_imm)`, where n is the number of set mask bits. The arithmetic is modulo 2^32.
- R5: With `mem_wready` held high, `busy` stays high for n+1 cycles when `ext_sel` is 00 and for n+2 cycles otherwise. `done` pulses in the first cycle after `busy` falls.
- R6: An all-zero mask issues no store at all and still applies the frame allocation.
- R7: `ext_sel` picks the extra value: 00 gives none (`ext_we` stays low), 01 gives the final stack pointer, 10 gives bits 15:0 of `ext_imm` sign-extended, and 11 gives all 32 bits of `ext_imm`. `ext_we` pulses together with `done`, and `ext_value` is valid in that cycle.
- R8: `done` lasts exactly one cycle, and `sp_out` keeps the final value after it.
- R9: A `start` pulse while `busy` is high is ignored. It does not change the stores or the final result of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| reg_list | input | 12 | Mask of registers to push; bit i = register 20+i |
| frame_imm | input | 5 | Unsigned frame size subtracted after the pushes |
| ext_sel | input | 2 | Extra value select: 00 none, 01 sp, 10 imm16, 11 imm32 |
| sp_in | input | 32 | Stack pointer at start |
| ext_imm | input | 32 | Trailing immediate word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| sp_out | output | 32 | Current / final stack pointer |
| rf_raddr | output | 5 | Register file read address |
| rf_rdata | input | 32 | Register file read data (combinational) |
| mem_wvalid | output | 1 | Store request |
| mem_wready | input | 1 | Memory accepts the store this cycle |
| mem_waddr | output | 32 | Store word address |
| mem_wdata | output | 32 | Store data |
| ext_we | output | 1 | Extra value write strobe |
| ext_value | output | 32 | Extra value |

## Verification
The hardest case to reach is a back-pressured store in the middle of a sparse mask. The stalled address and data must hold, the stack pointer must not move, and the next selected bit must not be picked early. In the bench a deterministic shift-register sequence drives `mem_wready` low on a share of the runs. The bench sweeps every one of the 4096 masks, so each gap pattern between set bits meets a stall somewhere. The frame size and the option field rotate with the mask, which covers all four option encodings and both signs of the 16-bit immediate. Extra runs start a new operation while `busy` is high, and others use a stack pointer that wraps around zero.

// File: rtl/frame_push_pkg.sv
package frame_push_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PUSH  = 2'd1,
    ST_ALLOC = 2'd2,
    ST_EXTRA = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    XSEL_NONE  = 2'b00,
    XSEL_SP    = 2'b01,
    XSEL_IMM16 = 2'b10,
    XSEL_IMM32 = 2'b11
  } xsel_e;

endpackage

// File: rtl/frame_pick_hi.sv
module frame_pick_hi #(
  parameter int W     = 12,
  localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]    bits,
  output logic [IDXW-1:0] idx,
  output logic            any
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) idx = IDXW'(i);
    end
    any = |bits;
  end
endmodule

// File: rtl/frame_xval_mux.sv
module frame_xval_mux
  import frame_push_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      sel,
  input  logic [XLEN-1:0] sp,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] value
);
  always_comb begin
    case (sel)
      XSEL_SP:    value = sp;
      XSEL_IMM16: value = {{(XLEN-16){imm[15]}}, imm[15:0]};
      XSEL_IMM32: value = imm;
      default:    value = '0;
    endcase
  end
endmodule

// File: rtl/frame_push_seq.sv
module frame_push_seq
  import frame_push_pkg::*;
#(
  parameter int LIST_W   = 12,
  parameter int IMM_W    = 5,
  parameter int XLEN     = 32,
  parameter int RADDR_W  = 5,
  parameter int BASE_REG = 20,
  localparam int IDXW    = (LIST_W > 1) ? $clog2(LIST_W) : 1,
  localparam int WORD_B  = XLEN / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LIST_W-1:0]  reg_list,
  input  logic [IMM_W-1:0]   frame_imm,
  input  logic [1:0]         ext_sel,
  input  logic [XLEN-1:0]    sp_in,
  input  logic [XLEN-1:0]    ext_imm,
  output logic               busy,
  output logic               done,
  output logic [XLEN-1:0]    sp_out,
  output logic [RADDR_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]    rf_rdata,
  output logic               mem_wvalid,
  input  logic               mem_wready,
  output logic [XLEN-1:0]    mem_waddr,
  output logic [XLEN-1:0]    mem_wdata,
  output logic               ext_we,
  output logic [XLEN-1:0]    ext_value
);

  seq_state_e        state_q, state_d;
  logic [LIST_W-1:0] list_q, list_d;
  logic [XLEN-1:0]   sp_q, sp_d;
  logic [IMM_W-1:0]  imm_q;
  logic [1:0]        sel_q;
  logic [XLEN-1:0]   xim_q;
  logic              done_q, done_d;
  logic              xwe_q, xwe_d;
  logic [XLEN-1:0]   xval_q;
  logic              ld_en;

  logic [IDXW-1:0]   pick_idx;
  logic              pick_any;
  logic [XLEN-1:0]   xval_w;
  logic [LIST_W-1:0] list_clr;
  logic [XLEN-1:0]   sp_dec;

  frame_pick_hi #(.W(LIST_W)) u_pick (
    .bits (list_q),
    .idx  (pick_idx),
    .any  (pick_any)
  );

  frame_xval_mux #(.XLEN(XLEN)) u_xval (
    .sel   (sel_q),
    .sp    (sp_q),
    .imm   (xim_q),
    .value (xval_w)
  );

  assign sp_dec   = sp_q - XLEN'(WORD_B);
  assign list_clr = list_q & ~(LIST_W'(1) << pick_idx);
  assign ld_en    = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    list_d  = list_q;
    sp_d    = sp_q;
    done_d  = 1'b0;
    xwe_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          list_d  = reg_list;
          sp_d    = sp_in;
          state_d = (|reg_list) ? ST_PUSH : ST_ALLOC;
        end
      end
      ST_PUSH: begin
        if (mem_wready && pick_any) begin
          sp_d   = sp_dec;
          list_d = list_clr;
          if (list_clr == '0) state_d = ST_ALLOC;
        end
      end
      ST_ALLOC: begin
        sp_d = sp_q - {{(XLEN-IMM_W){1'b0}}, imm_q};
        if (sel_q == XSEL_NONE) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_EXTRA;
        end
      end
      ST_EXTRA: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        xwe_d   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      list_q  <= '0;
      sp_q    <= '0;
      done_q  <= 1'b0;
      xwe_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      list_q  <= list_d;
      sp_q    <= sp_d;
      done_q  <= done_d;
      xwe_q   <= xwe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_q <= '0;
      sel_q <= XSEL_NONE;
      xim_q <= '0;
    end else if (ld_en) begin
      imm_q <= frame_imm;
      sel_q <= ext_sel;
      xim_q <= ext_imm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xval_q <= '0;
    end else if (xwe_d) begin
      xval_q <= xval_w;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign sp_out     = sp_q;
  assign rf_raddr   = RADDR_W'(BASE_REG) + RADDR_W'(pick_idx);
  assign mem_wvalid = (state_q == ST_PUSH);
  assign mem_waddr  = sp_dec;
  assign mem_wdata  = rf_rdata;
  assign ext_we     = xwe_q;
  assign ext_value  = xval_q;

endmodule

// File: rtl/frame_push_seq_chk.sv
module frame_push_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            mem_wvalid,
  input logic            mem_wready,
  input logic [XLEN-1:0] mem_waddr,
  input logic [XLEN-1:0] mem_wdata,
  input logic            ext_we
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_wvalid);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && mem_wready) |=>
      (!mem_wvalid || (mem_waddr == $past(mem_waddr) - XLEN'(4))));

  p_hold_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=>
      (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_ext_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind frame_push_seq frame_push_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .mem_wvalid (mem_wvalid),
  .mem_wready (mem_wready),
  .mem_waddr  (mem_waddr),
  .mem_wdata  (mem_wdata),
  .ext_we     (ext_we)
);

// File: tb/frame_push_seq_test.sv
module frame_push_seq_test;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [11:0] reg_list;
  logic [4:0]  frame_imm;
  logic [1:0]  ext_sel;
  logic [31:0] sp_in;
  logic [31:0] ext_imm;
  logic        busy, done, mem_wvalid, mem_wready, ext_we;
  logic [31:0] sp_out, mem_waddr, mem_wdata, rf_rdata, ext_value;
  logic [4:0]  rf_raddr;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  frame_push_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list),
    .frame_imm(frame_imm), .ext_sel(ext_sel), .sp_in(sp_in), .ext_imm(ext_imm),
    .busy(busy), .done(done), .sp_out(sp_out), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .ext_we(ext_we),
    .ext_value(ext_value)
  );

  // register file model: value identifies the register number
  assign rf_rdata = 32'hC0DE_0000 | {27'd0, rf_raddr};

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [11:0] lst, input logic [4:0] imm,
                         input logic [1:0] sel, input logic [31:0] sp0,
                         input logic [31:0] xim, input bit stall,
                         input bit restart);
    int n = 0;
    int k = 0;
    int cyc = 0;
    int guard = 0;
    int nxt = 11;
    logic [31:0] exp_sp;
    logic [31:0] exp_x;
    for (int i = 0; i < 12; i++) if (lst[i]) n++;
    exp_sp = sp0 - 32'(4 * n) - {27'd0, imm};
    case (sel)
      2'b01:   exp_x = exp_sp;
      2'b10:   exp_x = {{16{xim[15]}}, xim[15:0]};
      2'b11:   exp_x = xim;
      default: exp_x = 32'd0;
    endcase
    @(negedge clk);
    start = 1'b1; reg_list = lst; frame_imm = imm; ext_sel = sel;
    sp_in = sp0; ext_imm = xim; mem_wready = 1'b1;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 200) begin
        errors++; checks++;
        $display("FAIL R5: run hung, actual %0d expected %0d", guard, n + 2);
        break;
      end
      // R9: a second start while busy carries different fields
      if (restart && guard == 1) begin
        start = 1'b1; reg_list = ~lst; frame_imm = ~imm; sp_in = ~sp0;
      end else begin
        start = 1'b0;
      end
      if (busy) cyc++;
      if (mem_wvalid) begin
        while (nxt >= 0 && !lst[nxt]) nxt--;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_wready = stall ? lfsr[0] : 1'b1;
        check(mem_waddr == sp0 - 32'(4 * (k + 1)), "R2 addr", mem_waddr,
              sp0 - 32'(4 * (k + 1)));
        check(mem_wdata == (32'hC0DE_0000 | 32'(20 + nxt)), "R2 data",
              mem_wdata, 32'hC0DE_0000 | 32'(20 + nxt));
        if (mem_wready) begin k++; nxt--; end
      end else begin
        mem_wready = 1'b1;
      end
      if (done) begin
        check(k == n, (n == 0) ? "R6 store count" : "R2 store count",
              32'(k), 32'(n));
        check(sp_out == exp_sp, "R4 final sp", sp_out, exp_sp);
        if (!stall)
          check(cyc == n + ((sel == 2'b00) ? 1 : 2), "R5 busy cycles",
                32'(cyc), 32'(n + ((sel == 2'b00) ? 1 : 2)));
        check(ext_we == (sel != 2'b00), "R7 ext_we", {31'd0, ext_we},
              {31'd0, sel != 2'b00});
        if (sel != 2'b00)
          check(ext_value == exp_x, "R7 ext_value", ext_value, exp_x);
        @(negedge clk);
        check(!done && sp_out == exp_sp, "R8 done pulse / sp hold",
              {31'd0, done}, 32'd0);
        break;
      end
    end
  endtask

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; reg_list = '0; frame_imm = '0; ext_sel = '0;
    sp_in = '0; ext_imm = '0; mem_wready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_wvalid && !ext_we, "R1 reset state",
          {28'd0, busy, done, mem_wvalid, ext_we}, 32'd0);

    // corner cases
    run_one(12'h000, 5'd0,  2'b00, 32'h0000_1000, 32'd0, 1'b0, 1'b0); // R6
    run_one(12'h000, 5'd31, 2'b01, 32'h0000_1000, 32'd0, 1'b0, 1'b0); // R6
    run_one(12'hFFF, 5'd31, 2'b10, 32'h0000_0010, 32'h0000_8001, 1'b0, 1'b0);
    run_one(12'hFFF, 5'd0,  2'b11, 32'hFFFF_FFF0, 32'hDEAD_BEEF, 1'b1, 1'b0);
    run_one(12'h801, 5'd4,  2'b10, 32'h0000_2000, 32'h1234_7FFF, 1'b0, 1'b0);
    // R9: start pulsed while busy
    run_one(12'h0A5, 5'd9,  2'b01, 32'h4000_0000, 32'd0, 1'b0, 1'b1);
    run_one(12'h000, 5'd3,  2'b00, 32'h4000_0000, 32'd0, 1'b0, 1'b1);

    // full mask sweep with rotating frame size, option and stalls
    for (int m = 0; m < 4096; m++) begin
      run_one(12'(m), 5'((m * 7) % 32), 2'(m % 4),
              32'h8000_0000 + 32'(m * 64), 32'(m) * 32'h9E37_79B9,
              (m % 5) == 0, (m % 97) == 0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule